// File: doc/BRIEF.md
# SMBus Block Write / Block Read Process-Call Sequencer

This block is the host-side controller for the SMBus process call that first writes a block and then reads a block back. Software fills a shared 32-byte buffer, sets the target address, a command byte and the write count M, and pulses `go_i`. The sequencer then asks a bit-level bus engine beneath it for primitives: START, the address with the write bit, the command, M, the M data bytes, a repeated START with no STOP in front of it, the address with the read bit, and then it receives the count N and N data bytes. When packet error checking is on, it also receives a trailing check byte and compares it with a CRC-8 taken over every byte of the message.

The bytes that come back overwrite the same buffer from index 0. Software reads them through a pointer that steps on each read and is zeroed by a read of the command register. Completion raises a sticky done flag and a one-cycle interrupt. A length violation, a slave NACK or a bad check byte each set their own error flag.

Top module: `blkcall_seq`

## Requirements
- R1: On `go_i`, the sequencer refuses to start if `blk32_en_i` is 0, if `wr_cnt_i` is 0, or if `wr_cnt_i` exceeds 31. A refused start issues no bus primitive and sets `len_err_o`, `done_o` and a one-cycle `irq_o`.
- R2: An accepted transaction issues, in order, the primitives START, SEND {addr,0}, SEND command, SEND M, the M buffer bytes from index 0, RSTART, SEND {addr,1} and RECV. No STOP appears before RSTART. The `prim_op_o` encoding is START=0, RSTART=1, STOP=2, SEND=3, RECV=4.
- R3: If the received count N is 0 or M+N exceeds 32, the sequencer sets `len_err_o`, issues STOP and reads no data.
- R4: After a valid N, exactly N RECV primitives follow, and byte j is stored at buffer index j. With checking off, every RECV is ACKed (`prim_ack_o`=1) except the last data byte, which is NACKed. STOP follows.
- R5: With checking on, the last data byte is ACKed and one extra RECV with NACK takes the check byte, which is not counted in N. The check is a CRC-8 with polynomial 0x07, start value 0x00 and MSB first, taken over every byte from {addr,0} through the last data byte, including {addr,1} and N. A mismatch sets `pec_err_o`.
- R6: A NACK (`prim_nak_i`) on any sent byte sets `dev_err_o` and is followed directly by STOP with no further byte.
- R7: The software port writes (`sw_wr_i`) or reads (`sw_rd_i`) the buffer at a pointer that steps by one after each access. `sw_rdata_o` shows the byte at the pointer. A `cmd_rd_i` pulse zeroes the pointer, and it wins over a read in the same cycle.
- R8: After reset the sequencer is idle with all flags 0. Each transaction ends with `busy_o` low, `done_o` high and exactly one cycle of `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start pulse |
| blk32_en_i | input | 1 | 32-byte block mode enable |
| pec_en_i | input | 1 | Packet error check enable |
| tgt_addr_i | input | 7 | Target address |
| cmd_i | input | 8 | Command byte |
| wr_cnt_i | input | 6 | Write count M |
| sw_wr_i | input | 1 | Software buffer write, ignored while busy |
| sw_wdata_i | input | 8 | Software write data |
| sw_rd_i | input | 1 | Software buffer read step, ignored while busy |
| cmd_rd_i | input | 1 | Command-register read: zeroes the pointer |
| sw_rdata_o | output | 8 | Buffer byte at the software pointer |
| prim_req_o | output | 1 | One-cycle primitive request |
| prim_op_o | output | 3 | Primitive code |
| prim_tx_o | output | 8 | Byte to send |
| prim_ack_o | output | 1 | 1 = ACK the received byte, 0 = NACK |
| prim_done_i | input | 1 | Primitive complete |
| prim_rx_i | input | 8 | Received byte, valid with done |
| prim_nak_i | input | 1 | Slave NACKed the sent byte, valid with done |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Completion pulse |
| len_err_o | output | 1 | Length or mode error |
| dev_err_o | output | 1 | Slave NACK error |
| pec_err_o | output | 1 | Check byte mismatch |

## Verification
Two software-port functions can fall in the same cycle: a pointer clear from a command-register read and a read step. The bench writes three known bytes, steps the pointer to 2, and then raises `cmd_rd_i` and `sw_rd_i` together. It expects the first byte on `sw_rdata_o`, which shows that the clear won. On the bus side, the bench checks that the sequencer stops at the count byte at the M+N=32/33 boundary: N=12 with M=20 must be accepted, and N=13 must be refused. The bench also sweeps M and N over 1..4, with the check byte on and off, and compares the full primitive log and the buffer contents with values it computes itself.

// File: rtl/blkcall_pkg.sv
// Shared types for the block process-call sequencer.
// Assumes: primitive codes are fixed, the bus engine decodes them.
package blkcall_pkg;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_STOP   = 3'd2,
        OP_SEND   = 3'd3,
        OP_RECV   = 3'd4
    } bus_op_e;

    // One byte of CRC-8, poly 0x07, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc ^ data;
        for (int k = 0; k < 8; k++) begin
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pec_acc.sv
// Running packet-error-check accumulator.
// Assumes: clr and upd never both high in one cycle.
module pec_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] byte_i,
    output logic [7:0] crc_o
);
    import blkcall_pkg::*;

    // Accumulate the CRC over each byte seen on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_o <= 8'h00;
        else if (clr) crc_o <= 8'h00;
        else if (upd) crc_o <= crc8_step(crc_o, byte_i);
    end

    AST_PEC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) clr |=> crc_o == 8'h00) else $error("pec clear"); // R5

endmodule

// File: rtl/blk_buf.sv
// Shared block data buffer with a software pointer port and a sequencer index port.
// Assumes: software and sequencer never write in the same cycle (top gates software while busy).
module blk_buf #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic [7:0]    sw_wdata,
    input  logic          sw_rd,
    input  logic          ptr_clr,
    output logic [7:0]    sw_rdata,
    input  logic [AW-1:0] sq_idx,
    output logic [7:0]    sq_rdata,
    input  logic          sq_wr,
    input  logic [7:0]    sq_wdata
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] ptr;

    // Software pointer: clear wins, otherwise step on each access.
    always_ff @(posedge clk) begin
        if (!rst_n)               ptr <= '0;
        else if (ptr_clr)         ptr <= '0;
        else if (sw_wr || sw_rd)  ptr <= ptr + 1'b1;
    end

    // Storage writes from either port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (sq_wr) begin
            mem[sq_idx] <= sq_wdata;
        end else if (sw_wr) begin
            mem[ptr] <= sw_wdata;
        end
    end

    assign sw_rdata = mem[ptr];
    assign sq_rdata = mem[sq_idx];

    AST_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ptr_clr |=> ptr == '0) else $error("ptr clear"); // R7

endmodule

// File: rtl/blkcall_seq.sv
// Block write / block read process-call sequencer.
// Drives one primitive at a time to a bit-level bus engine and waits for its done.
// Assumes: prim_done_i comes at least one cycle after prim_req_o, and only once per request.
module blkcall_seq #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          blk32_en_i,
    input  logic          pec_en_i,
    input  logic [6:0]    tgt_addr_i,
    input  logic [7:0]    cmd_i,
    input  logic [CW-1:0] wr_cnt_i,
    input  logic          sw_wr_i,
    input  logic [7:0]    sw_wdata_i,
    input  logic          sw_rd_i,
    input  logic          cmd_rd_i,
    output logic [7:0]    sw_rdata_o,
    output logic          prim_req_o,
    output logic [2:0]    prim_op_o,
    output logic [7:0]    prim_tx_o,
    output logic          prim_ack_o,
    input  logic          prim_done_i,
    input  logic [7:0]    prim_rx_i,
    input  logic          prim_nak_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          irq_o,
    output logic          len_err_o,
    output logic          dev_err_o,
    output logic          pec_err_o
);
    import blkcall_pkg::*;

    localparam logic [8:0] LIM = 9'(DEPTH);

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDRW, S_CMD, S_WCNT, S_WDATA,
        S_RSTART, S_ADDRR, S_RCNT, S_RDATA, S_RPEC, S_STOP
    } st_e;

    st_e           st;
    logic          pend;
    logic [CW-1:0] idx, wcnt, ncnt;
    logic [6:0]    addr;
    logic [7:0]    cmd;
    logic          pec_on;
    bus_op_e       op_c, last_op;
    logic [7:0]    sq_rdata, crc;
    logic          bad_start, fin, last_rd, n_ok, crc_upd, crc_clr;

    assign bad_start = !blk32_en_i || (wr_cnt_i == '0) || (wr_cnt_i > CW'(DEPTH - 1));
    assign fin       = pend && prim_done_i;
    assign last_rd   = (idx == ncnt - 1'b1);
    assign n_ok      = (prim_rx_i != 8'h00) && (({1'b0, prim_rx_i} + {{(9-CW){1'b0}}, wcnt}) <= LIM);
    assign crc_clr   = (st == S_IDLE) && go_i && !bad_start;
    assign crc_upd   = fin && (op_c == OP_SEND || st == S_RCNT || st == S_RDATA);

    // Primitive selection per state.
    always_comb begin
        op_c       = OP_SEND;
        prim_tx_o  = 8'h00;
        prim_ack_o = 1'b1;
        case (st)
            S_START:  op_c = OP_START;
            S_ADDRW:  prim_tx_o = {addr, 1'b0};
            S_CMD:    prim_tx_o = cmd;
            S_WCNT:   prim_tx_o = 8'(wcnt);
            S_WDATA:  prim_tx_o = sq_rdata;
            S_RSTART: op_c = OP_RSTART;
            S_ADDRR:  prim_tx_o = {addr, 1'b1};
            S_RCNT:   op_c = OP_RECV;
            S_RDATA:  begin op_c = OP_RECV; prim_ack_o = !(last_rd && !pec_on); end
            S_RPEC:   begin op_c = OP_RECV; prim_ack_o = 1'b0; end
            default:  op_c = OP_STOP;
        endcase
    end

    assign prim_op_o  = op_c;
    assign prim_req_o = (st != S_IDLE) && !pend;
    assign busy_o     = (st != S_IDLE);

    // Sequence control: one request, wait for done, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; pend <= 1'b0; idx <= '0; wcnt <= '0; ncnt <= '0;
            addr <= '0; cmd <= '0; pec_on <= 1'b0; last_op <= OP_STOP;
            done_o <= 1'b0; irq_o <= 1'b0;
            len_err_o <= 1'b0; dev_err_o <= 1'b0; pec_err_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (prim_req_o) begin
                pend    <= 1'b1;
                last_op <= op_c;
            end
            if (st == S_IDLE) begin
                if (go_i && bad_start) begin
                    len_err_o <= 1'b1; dev_err_o <= 1'b0; pec_err_o <= 1'b0;
                    done_o <= 1'b1; irq_o <= 1'b1;
                end else if (go_i) begin
                    addr <= tgt_addr_i; cmd <= cmd_i; wcnt <= wr_cnt_i; pec_on <= pec_en_i;
                    len_err_o <= 1'b0; dev_err_o <= 1'b0; pec_err_o <= 1'b0;
                    done_o <= 1'b0; idx <= '0; st <= S_START;
                end
            end else if (fin) begin
                pend <= 1'b0;
                if (op_c == OP_SEND && prim_nak_i) begin
                    dev_err_o <= 1'b1;
                    st <= S_STOP;
                end else begin
                    case (st)
                        S_START:  st <= S_ADDRW;
                        S_ADDRW:  st <= S_CMD;
                        S_CMD:    st <= S_WCNT;
                        S_WCNT:   begin idx <= '0; st <= S_WDATA; end
                        S_WDATA:  if (idx == wcnt - 1'b1) st <= S_RSTART; else idx <= idx + 1'b1;
                        S_RSTART: st <= S_ADDRR;
                        S_ADDRR:  st <= S_RCNT;
                        S_RCNT:   if (n_ok) begin
                                      ncnt <= prim_rx_i[CW-1:0]; idx <= '0; st <= S_RDATA;
                                  end else begin
                                      len_err_o <= 1'b1; st <= S_STOP;
                                  end
                        S_RDATA:  if (last_rd) st <= pec_on ? S_RPEC : S_STOP; else idx <= idx + 1'b1;
                        S_RPEC:   begin
                                      if (prim_rx_i != crc) pec_err_o <= 1'b1;
                                      st <= S_STOP;
                                  end
                        default:  begin st <= S_IDLE; done_o <= 1'b1; irq_o <= 1'b1; end
                    endcase
                end
            end
        end
    end

    pec_acc u_pec (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .upd    (crc_upd),
        .byte_i (op_c == OP_SEND ? prim_tx_o : prim_rx_i),
        .crc_o  (crc)
    );

    blk_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (sw_wr_i && !busy_o),
        .sw_wdata (sw_wdata_i),
        .sw_rd    (sw_rd_i && !busy_o),
        .ptr_clr  (cmd_rd_i),
        .sw_rdata (sw_rdata_o),
        .sq_idx   (idx[AW-1:0]),
        .sq_rdata (sq_rdata),
        .sq_wr    (fin && st == S_RDATA),
        .sq_wdata (prim_rx_i)
    );

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE && go_i && bad_start) |=> (!busy_o && irq_o && len_err_o)) else $error("reject"); // R1
    AST_NO_STOP_BEFORE_RSTART: assert property (@(posedge clk) disable iff (!rst_n) (prim_req_o && op_c == OP_RSTART) |-> last_op == OP_SEND) else $error("rstart"); // R2
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n) prim_req_o |=> !prim_req_o) else $error("req"); // R2
    AST_NAK_STOP: assert property (@(posedge clk) disable iff (!rst_n) (fin && op_c == OP_SEND && prim_nak_i) |=> (st == S_STOP && dev_err_o)) else $error("nak"); // R6
    AST_PEC_ERR_NEEDS_PEC: assert property (@(posedge clk) disable iff (!rst_n) pec_err_o |-> pec_on) else $error("pec flag"); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o) else $error("irq"); // R8

endmodule

// File: tb/blkcall_seq_bench.sv
module blkcall_seq_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, go_i, blk32_en_i, pec_en_i, sw_wr_i, sw_rd_i, cmd_rd_i;
    logic [6:0] tgt_addr_i;
    logic [7:0] cmd_i, sw_wdata_i, sw_rdata_o, prim_tx_o, prim_rx_i;
    logic [5:0] wr_cnt_i;
    logic prim_req_o, prim_ack_o, prim_done_i, prim_nak_i;
    logic [2:0] prim_op_o;
    logic busy_o, done_o, irq_o, len_err_o, dev_err_o, pec_err_o;

    blkcall_seq u_blkcall_seq (.*);

    int n_tests = 0, n_fail = 0;
    logic [2:0] lg_op [0:127];
    logic [7:0] lg_b [0:127];
    logic       lg_ack [0:127];
    int n_lg = 0;
    logic [7:0] rsp [0:63];
    int rsp_i = 0, nak_at = -1, send_cnt = 0, eng_cnt = 0;
    logic [7:0] eng_rx;
    logic eng_nk;

    logic [2:0] ex_op [0:127];
    logic [7:0] ex_b [0:127];
    logic       ex_ack [0:127];
    int n_ex;

    // Bus engine model: log each request, answer two cycles later.
    initial begin
        prim_done_i = 0; prim_nak_i = 0; prim_rx_i = 0;
        forever begin
            @(negedge clk);
            prim_done_i = 0; prim_nak_i = 0;
            if (eng_cnt > 0) begin
                eng_cnt--;
                if (eng_cnt == 0) begin
                    prim_done_i = 1; prim_rx_i = eng_rx; prim_nak_i = eng_nk;
                end
            end else if (prim_req_o) begin
                lg_op[n_lg] = prim_op_o; lg_b[n_lg] = prim_tx_o; lg_ack[n_lg] = prim_ack_o;
                n_lg++;
                eng_nk = 0; eng_rx = 0;
                if (prim_op_o == 3'd3) begin
                    if (send_cnt == nak_at) eng_nk = 1;
                    send_cnt++;
                end
                if (prim_op_o == 3'd4) begin eng_rx = rsp[rsp_i]; rsp_i++; end
                eng_cnt = 2;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [7:0] bcrc(logic [7:0] c, logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[7] ^ d[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic ex(logic [2:0] op, logic [7:0] b, logic a);
        ex_op[n_ex] = op; ex_b[n_ex] = b; ex_ack[n_ex] = a; n_ex++;
    endtask

    task automatic pulse_cmd_rd();
        cmd_rd_i = 1; @(negedge clk); cmd_rd_i = 0;
    endtask

    task automatic sw_write(logic [7:0] d);
        sw_wdata_i = d; sw_wr_i = 1; @(negedge clk); sw_wr_i = 0;
    endtask

    // One transaction with expected log, flags and buffer built here.
    task automatic run(int m, int nf, bit pec, bit badpec, int nk, bit en, string tag);
        logic [7:0] c;
        logic [7:0] wd [0:63];
        logic [7:0] rd [0:63];
        bit bad, ok_n, exp_dev, exp_len;
        int irqs, waitc, sidx;
        pulse_cmd_rd();
        for (int i = 0; i < m && i < 32; i++) begin
            wd[i] = 8'((i * 37 + m * 5 + 1) & 255);
            sw_write(wd[i]);
        end
        tgt_addr_i = 7'(7'h2C + m); cmd_i = 8'(8'hA0 + nf);
        wr_cnt_i = 6'(m); pec_en_i = pec; blk32_en_i = en;
        bad = !en || m == 0 || m > 31;
        ok_n = nf != 0 && m + nf <= 32;
        n_ex = 0; exp_dev = 0; exp_len = bad; c = 8'h00; sidx = 0;
        if (!bad) begin
            ex(3'd0, 0, 1);
            ex(3'd3, {tgt_addr_i, 1'b0}, 1); c = bcrc(c, {tgt_addr_i, 1'b0});
            if (nk == sidx) exp_dev = 1; sidx++;
            if (!exp_dev) begin ex(3'd3, cmd_i, 1); c = bcrc(c, cmd_i); if (nk == sidx) exp_dev = 1; sidx++; end
            if (!exp_dev) begin ex(3'd3, 8'(m), 1); c = bcrc(c, 8'(m)); if (nk == sidx) exp_dev = 1; sidx++; end
            for (int i = 0; i < m; i++) if (!exp_dev) begin
                ex(3'd3, wd[i], 1); c = bcrc(c, wd[i]); if (nk == sidx) exp_dev = 1; sidx++;
            end
            if (!exp_dev) begin
                ex(3'd1, 0, 1);
                ex(3'd3, {tgt_addr_i, 1'b1}, 1); c = bcrc(c, {tgt_addr_i, 1'b1});
                if (nk == sidx) exp_dev = 1;
            end
            if (!exp_dev) begin
                ex(3'd4, 0, 1); c = bcrc(c, 8'(nf));
                if (!ok_n) exp_len = 1;
                else begin
                    for (int j = 0; j < nf; j++) begin
                        rd[j] = 8'((j * 29 + nf * 3 + 128) & 255);
                        ex(3'd4, 0, (j < nf - 1) || pec); c = bcrc(c, rd[j]);
                    end
                    if (pec) ex(3'd4, 0, 0);
                end
            end
            ex(3'd2, 0, 1);
        end
        rsp[0] = 8'(nf);
        for (int j = 0; j < nf && j < 40; j++) rsp[1 + j] = rd[j];
        if (nf < 40) rsp[1 + nf] = c ^ (badpec ? 8'h01 : 8'h00);
        n_lg = 0; rsp_i = 0; send_cnt = 0; nak_at = nk;
        go_i = 1; @(negedge clk); go_i = 0;
        irqs = 0; waitc = 0;
        if (irq_o) irqs++;
        while (irqs == 0 && waitc < 3000) begin @(negedge clk); if (irq_o) irqs++; waitc++; end
        repeat (3) begin @(negedge clk); if (irq_o) irqs++; end
        chk(irqs == 1, "R8", {tag, " irq pulses"}, irqs, 1);
        chk(done_o && !busy_o, "R8", {tag, " done/idle"}, {done_o, busy_o}, 2);
        chk(n_lg == n_ex, tag, "primitive count", n_lg, n_ex);
        for (int k = 0; k < n_ex && k < n_lg; k++) begin
            bit okk;
            okk = lg_op[k] == ex_op[k];
            if (ex_op[k] == 3'd3) okk = okk && lg_b[k] == ex_b[k];
            if (ex_op[k] == 3'd4) okk = okk && lg_ack[k] == ex_ack[k];
            if (!okk) chk(0, tag, $sformatf("primitive %0d op/byte/ack", k),
                          {lg_op[k], lg_b[k], lg_ack[k]}, {ex_op[k], ex_b[k], ex_ack[k]});
        end
        chk(len_err_o == exp_len, bad ? "R1" : "R3", {tag, " len_err"}, len_err_o, exp_len);
        chk(dev_err_o == exp_dev, "R6", {tag, " dev_err"}, dev_err_o, exp_dev);
        chk(pec_err_o == (pec && badpec && !bad && !exp_dev && ok_n), "R5", {tag, " pec_err"},
            pec_err_o, pec && badpec && !bad && !exp_dev && ok_n);
        if (!bad && !exp_dev && ok_n) begin
            pulse_cmd_rd();
            for (int j = 0; j < nf; j++) begin
                chk(sw_rdata_o == rd[j], "R4", $sformatf("%s read byte %0d", tag, j), sw_rdata_o, rd[j]);
                sw_rd_i = 1; @(negedge clk); sw_rd_i = 0;
            end
        end
    endtask

    initial begin
        rst_n = 0; go_i = 0; blk32_en_i = 1; pec_en_i = 0; sw_wr_i = 0; sw_rd_i = 0; cmd_rd_i = 0;
        tgt_addr_i = 0; cmd_i = 0; sw_wdata_i = 0; wr_cnt_i = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !irq_o && !len_err_o && !dev_err_o && !pec_err_o && !prim_req_o,
            "R8", "reset state", {busy_o, done_o, irq_o, len_err_o, dev_err_o, pec_err_o}, 0);

        // R2 R4 R5 sweep over small M, N, check on/off.
        for (int m = 1; m <= 4; m++)
            for (int n = 1; n <= 4; n++)
                for (int p = 0; p < 2; p++)
                    run(m, n, p[0], 0, -1, 1, p ? "R5" : "R2");

        run(31, 1, 1, 0, -1, 1, "R3");  // largest legal M
        run(20, 12, 0, 0, -1, 1, "R3"); // M+N = 32
        run(20, 13, 0, 0, -1, 1, "R3"); // M+N = 33
        run(3, 0, 1, 0, -1, 1, "R3");   // N = 0
        run(2, 2, 0, 0, -1, 0, "R1");   // mode disabled
        run(0, 2, 0, 0, -1, 1, "R1");   // M = 0
        run(32, 1, 0, 0, -1, 1, "R1");  // M = 32
        run(3, 3, 1, 1, -1, 1, "R5");   // corrupted check byte
        run(2, 3, 1, 0, 0, 1, "R6");    // NACK on address+W
        run(2, 3, 0, 0, 3, 1, "R6");    // NACK on first data byte
        run(2, 3, 0, 0, 5, 1, "R6");    // NACK on address+R

        // R7: pointer stepping and clear colliding with a read.
        pulse_cmd_rd();
        sw_write(8'h11); sw_write(8'h22); sw_write(8'h33);
        pulse_cmd_rd();
        chk(sw_rdata_o == 8'h11, "R7", "pointer at 0", sw_rdata_o, 8'h11);
        sw_rd_i = 1; @(negedge clk); @(negedge clk); sw_rd_i = 0;
        chk(sw_rdata_o == 8'h33, "R7", "pointer stepped to 2", sw_rdata_o, 8'h33);
        cmd_rd_i = 1; sw_rd_i = 1; @(negedge clk); cmd_rd_i = 0; sw_rd_i = 0;
        chk(sw_rdata_o == 8'h11, "R7", "clear wins over read", sw_rdata_o, 8'h11);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule